// File: doc/BRIEF.md
# Serial Control Slave for an Audio Processor

This block is a two-wire bus slave for a small audio processing device. It oversamples the serial clock and data lines with the system clock and finds start and stop conditions. It matches a 7-bit device address and, on a write, loads a bank of write-only control bytes. A host sends a subaddress byte and then a run of data bytes. The pointer steps up by one after each byte.

A read has no subaddress phase. After the address byte with the direction bit set, the slave shifts out one status byte. Bit 7 of that byte is a power-up flag. Bits 6:5 carry the detected broadcast type, taken from an input. The remaining bits are zero. The flag is set by reset and cleared once a status read finishes.

Subaddress map: 0x00 switch control, 0x01 an inert slot (acknowledged, never stored), 0x02 level, 0x03 stereo trim, 0x04 test. The data line is only ever pulled low through an output enable.

Top module: `i2c_audio_ctl`

## Requirements
- R1: `busy_o` goes high after a start condition (SDA falls while SCL is high) and low after a stop condition (SDA rises while SCL is high).
- R2: An address byte whose upper 7 bits equal `SLAVE_ADDR` (default 0x42) is acknowledged. Any other address gets no acknowledge, and the rest of that transfer is ignored until a start or stop.
- R3: A write (address bit 0 = 0) takes a subaddress and then data bytes. Each byte is acknowledged and stored at the pointer, and the pointer then increments.
- R4: A data byte sent to subaddress 0x01 is acknowledged but changes no output. The pointer still advances to 0x02.
- R5: A subaddress byte from 0x05 to 0xFF is not acknowledged, and no data in that transfer is stored.
- R6: Once the pointer has passed 0x04, further data bytes in that transfer are neither acknowledged nor stored.
- R7: A read (address bit 0 = 1) returns one status byte MSB first, with no subaddress phase: {por_flag, ident_i[1:0], 5'b00000}.
- R8: The power-up flag is 1 after reset. It is 0 on every read that follows a completed status read.
- R9: A start condition in the middle of a transfer discards the partial byte and restarts address decoding.
- R10: After reset all four control outputs are 0x00, `sda_oe_o` is 0 and `busy_o` is 0.
- R11: `sda_oe_o` only asserts while the synchronized SCL is low. It is released after each acknowledge or read data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| ident_i | input | 2 | Detected broadcast type, reported in status bits 6:5 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Bus busy between start and stop |
| switch_o | output | 8 | Control byte at subaddress 0x00 |
| level_o | output | 8 | Control byte at subaddress 0x02 |
| stereo_o | output | 8 | Control byte at subaddress 0x03 |
| test_o | output | 8 | Control byte at subaddress 0x04 |

## Verification
A burst from 0x00 through the end of the map checks the inert slot. A design that stored that byte, or did not advance past it, would corrupt the switch or level byte. A sixth byte past 0x04 must be refused; a pointer that wrapped or saturated would acknowledge it and overwrite a register. Subaddresses 0x05 and 0xFF and a foreign device address must draw no acknowledge and store nothing. Back-to-back reads show whether the power-up flag clears only after a finished read. A restart inside a data byte catches a slave that keeps its half-shifted bits.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_DATA, ST_DATA_ACK, ST_RD_BYTE, ST_RD_ACK, ST_SKIP
  } bus_st_e;

  localparam int unsigned NUM_SUB   = 5;           // subaddresses 0..4
  localparam logic [7:0]  DEAD_SLOT = 8'h01;       // acked, never stored
  localparam int unsigned NUM_STORE = NUM_SUB - 1;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_ctl_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR = 7'h42,
  parameter int unsigned NSUB       = NUM_SUB
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] status_i,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       por_clr_o
);
  localparam logic [7:0] LAST_SUB = 8'(NSUB - 1);

  bus_st_e    state_q;
  logic [2:0] cnt_q;
  logic [7:0] sh_q, tx_q, ptr_q;
  logic       done_q, rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      done_q    <= 1'b0;
      rw_q      <= 1'b0;
      sda_oe_o  <= 1'b0;
      busy_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      por_clr_o <= 1'b0;
    end else begin
      wr_en_o   <= 1'b0;
      por_clr_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        done_q   <= 1'b0;
        sda_oe_o <= 1'b0;
        busy_o   <= 1'b1;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        done_q   <= 1'b0;
        sda_oe_o <= 1'b0;
        busy_o   <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_SUB, ST_DATA: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 3'd1;
              if (cnt_q == 3'd7) done_q <= 1'b1;
            end else if (scl_fall_i && done_q) begin
              done_q  <= 1'b0;
              state_q <= ST_SKIP;
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == SLAVE_ADDR) begin
                  sda_oe_o <= 1'b1;
                  rw_q     <= sh_q[0];
                  state_q  <= ST_ADDR_ACK;
                end
              end else if (state_q == ST_SUB) begin
                if (sh_q <= LAST_SUB) begin
                  sda_oe_o <= 1'b1;
                  ptr_q    <= sh_q;
                  state_q  <= ST_SUB_ACK;
                end
              end else if (ptr_q <= LAST_SUB) begin
                sda_oe_o  <= 1'b1;
                wr_en_o   <= (ptr_q != DEAD_SLOT);
                wr_addr_o <= ptr_q;
                wr_data_o <= sh_q;
                ptr_q     <= ptr_q + 8'd1;
                state_q   <= ST_DATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q     <= status_i;
              sda_oe_o <= ~status_i[7];
              state_q  <= ST_RD_BYTE;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_SUB;
            end
          end
          ST_SUB_ACK, ST_DATA_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_DATA;
          end
          ST_RD_BYTE: if (scl_fall_i) begin
            if (cnt_q == 3'd7) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_RD_ACK;
            end else begin
              tx_q     <= {tx_q[6:0], 1'b0};
              sda_oe_o <= ~tx_q[6];
              cnt_q    <= cnt_q + 3'd1;
            end
          end
          ST_RD_ACK: if (scl_rise_i) begin
            por_clr_o <= 1'b1;
            state_q   <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  busy_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  // R5
  sub_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUB_ACK) |-> (ptr_q <= LAST_SUB));
  // R7
  rd_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_BYTE && sda_oe_o) |-> !tx_q[7]);
  // R8
  por_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_clr_o |-> $past(state_q == ST_RD_ACK));
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import i2c_ctl_pkg::*;
#(
  parameter int unsigned NSTORE = NUM_STORE,
  parameter int unsigned NSUB   = NUM_SUB
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [7:0]             wr_addr_i,
  input  logic [7:0]             wr_data_i,
  input  logic                   por_clr_i,
  output logic [NSTORE-1:0][7:0] regs_o,
  output logic                   por_o
);
  logic [7:0] slot;

  // subaddresses above the inert slot shift down by one storage index
  always_comb slot = (wr_addr_i > DEAD_SLOT) ? wr_addr_i - 8'd1 : wr_addr_i;

  for (genvar i = 0; i < NSTORE; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_o[i] <= '0;
      else if (wr_en_i && slot == 8'(i))    regs_o[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        por_o <= 1'b1;
    else if (por_clr_i) por_o <= 1'b0;
  end

  // R4
  dead_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_addr_i != DEAD_SLOT && wr_addr_i < 8'(NSUB)));
endmodule

// File: rtl/i2c_audio_ctl.sv
module i2c_audio_ctl
  import i2c_ctl_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR  = 7'h42,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] ident_i,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic [7:0] switch_o,
  output logic [7:0] level_o,
  output logic [7:0] stereo_o,
  output logic [7:0] test_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, por_clr, por_flag;
  logic [7:0] wr_addr, wr_data, status;
  logic [NUM_STORE-1:0][7:0] regs;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign status = {por_flag, ident_i, 5'b00000};

  i2c_slave_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .NSUB(NUM_SUB)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .status_i(status),
    .sda_oe_o, .busy_o, .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .por_clr_o(por_clr)
  );

  ctl_reg_bank #(.NSTORE(NUM_STORE), .NSUB(NUM_SUB)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .por_clr_i(por_clr), .regs_o(regs), .por_o(por_flag)
  );

  assign switch_o = regs[0];
  assign level_o  = regs[1];
  assign stereo_o = regs[2];
  assign test_o   = regs[3];

  // R11
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);
endmodule

// File: tb/i2c_audio_ctl_test.sv
module i2c_audio_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [6:0] DEV = 7'h42;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic [1:0] ident = 2'b00;
  logic sda_oe, busy, sda_line;
  logic [7:0] sw, lvl, ster, tst;
  int errs = 0, checks = 0;

  assign sda_line = sda_oe ? 1'b0 : m_sda;

  i2c_audio_ctl #(.SLAVE_ADDR(DEV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .ident_i(ident),
    .sda_oe_o(sda_oe), .busy_o(busy), .switch_o(sw), .level_o(lvl),
    .stereo_o(ster), .test_o(tst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wt(HALF); scl = 1'b1; wt(HALF);
    m_sda = 1'b0; wt(HALF); scl = 1'b0; wt(HALF);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wt(HALF); scl = 1'b1; wt(HALF); m_sda = 1'b1; wt(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      m_sda = b[7-i]; wt(HALF); scl = 1'b1; wt(HALF); scl = 1'b0;
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; wt(HALF); scl = 1'b1; wt(HALF/2);
    ack = ~sda_line; wt(HALF/2); scl = 1'b0; wt(HALF);
  endtask

  task automatic rbyte(output logic [7:0] b, input logic mack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(HALF); scl = 1'b1; wt(HALF/2); b[i] = sda_line; wt(HALF/2); scl = 1'b0;
    end
    m_sda = ~mack; wt(HALF); scl = 1'b1; wt(HALF); scl = 1'b0; wt(HALF); m_sda = 1'b1;
  endtask

  task automatic read_status(output logic [7:0] st, output logic ack);
    bus_start;
    wbyte({DEV, 1'b1}, ack);
    rbyte(st, 1'b0);
    bus_stop;
  endtask

  task automatic t_reset;
    chk("R10 switch", sw, 8'h00);
    chk("R10 level", lvl, 8'h00);
    chk("R10 stereo", ster, 8'h00);
    chk("R10 test", tst, 8'h00);
    chk("R10 oe/busy", {6'd0, sda_oe, busy}, 8'h00);
  endtask

  task automatic t_read_por;
    logic ack; logic [7:0] st;
    ident = 2'b10;
    bus_start;
    chk("R1 busy after start", {7'd0, busy}, 8'h01);
    wbyte({DEV, 1'b1}, ack);
    chk("R2 read addr ack", {7'd0, ack}, 8'h01);
    rbyte(st, 1'b0);
    bus_stop;
    chk("R1 busy after stop", {7'd0, busy}, 8'h00);
    chk("R7 R8 first status", st, 8'hC0);
    read_status(st, ack);
    chk("R8 flag cleared", st, 8'h40);
  endtask

  task automatic t_burst;
    logic ack;
    bus_start;
    wbyte({DEV, 1'b0}, ack); chk("R2 write addr ack", {7'd0, ack}, 8'h01);
    wbyte(8'h00, ack);       chk("R3 sub ack", {7'd0, ack}, 8'h01);
    wbyte(8'hA1, ack);       chk("R3 data0 ack", {7'd0, ack}, 8'h01);
    wbyte(8'hB2, ack);       chk("R4 inert ack", {7'd0, ack}, 8'h01);
    wbyte(8'hC3, ack);       chk("R3 data2 ack", {7'd0, ack}, 8'h01);
    wbyte(8'hD4, ack);       chk("R3 data3 ack", {7'd0, ack}, 8'h01);
    wbyte(8'hE5, ack);       chk("R3 data4 ack", {7'd0, ack}, 8'h01);
    wbyte(8'h77, ack);       chk("R6 past end nack", {7'd0, ack}, 8'h00);
    bus_stop;
    chk("R3 switch", sw, 8'hA1);
    chk("R3 R4 level", lvl, 8'hC3);
    chk("R3 stereo", ster, 8'hD4);
    chk("R3 R6 test", tst, 8'hE5);
  endtask

  task automatic t_dead_slot;
    logic ack;
    bus_start;
    wbyte({DEV, 1'b0}, ack);
    wbyte(8'h01, ack); chk("R4 sub 01 ack", {7'd0, ack}, 8'h01);
    wbyte(8'h11, ack); chk("R4 data to 01 ack", {7'd0, ack}, 8'h01);
    wbyte(8'h22, ack);
    bus_stop;
    chk("R4 next goes to level", lvl, 8'h22);
    chk("R4 switch untouched", sw, 8'hA1);
    chk("R4 stereo untouched", ster, 8'hD4);
  endtask

  task automatic t_bad_sub;
    logic ack;
    bus_start;
    wbyte({DEV, 1'b0}, ack);
    wbyte(8'h05, ack); chk("R5 sub 05 nack", {7'd0, ack}, 8'h00);
    wbyte(8'h66, ack); chk("R5 data nack", {7'd0, ack}, 8'h00);
    bus_stop;
    bus_start;
    wbyte({DEV, 1'b0}, ack);
    wbyte(8'hFF, ack); chk("R5 sub FF nack", {7'd0, ack}, 8'h00);
    wbyte(8'h66, ack);
    bus_stop;
    chk("R5 switch kept", sw, 8'hA1);
    chk("R5 test kept", tst, 8'hE5);
  endtask

  task automatic t_wrong_addr;
    logic ack;
    bus_start;
    wbyte({7'h43, 1'b0}, ack); chk("R2 foreign nack", {7'd0, ack}, 8'h00);
    wbyte(8'h00, ack);         chk("R2 ignored sub nack", {7'd0, ack}, 8'h00);
    wbyte(8'h33, ack);
    bus_stop;
    chk("R2 switch kept", sw, 8'hA1);
  endtask

  task automatic t_restart;
    logic ack;
    bus_start;
    wbyte({DEV, 1'b0}, ack);
    wbyte(8'h02, ack);
    send_bits(8'h99, 5);
    bus_start;
    wbyte({DEV, 1'b0}, ack); chk("R9 addr after restart", {7'd0, ack}, 8'h01);
    wbyte(8'h03, ack);
    wbyte(8'h5A, ack);
    bus_stop;
    chk("R9 stereo written", ster, 8'h5A);
    chk("R9 level untouched", lvl, 8'h22);
  endtask

  task automatic t_ident;
    logic ack; logic [7:0] st;
    ident = 2'b00;
    read_status(st, ack);
    chk("R7 mono status", st, 8'h00);
    ident = 2'b01;
    read_status(st, ack);
    chk("R7 ident 01 status", st, 8'h20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report;
    $finish;
  end

  initial begin
    wt(5); rst_n = 1'b1; wt(5);
    t_reset;
    t_read_por;
    t_burst;
    t_dead_slot;
    t_bad_sub;
    t_wrong_addr;
    t_restart;
    t_ident;
    report;
    $finish;
  end
endmodule